// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target end of a two-wire serial memory. It watches the clock and data lines of the bus and finds start and stop conditions. It checks each device address byte against its own address. When a write is addressed to it, it takes in a two-byte word address and then data bytes, which it stores in an internal byte array. When a read is addressed to it, it shifts bytes out of that array. A persistent byte pointer holds one past the last location that was read or written. A read that supplies no address therefore continues from where the previous access stopped. A write that carries only a word address and no data (a dummy write) moves the pointer, so the read that follows it with a repeated start returns the byte the host asked for.

Both bus lines are first brought into the system clock domain, and SCL edges are found by oversampling. The data line is open-drain. The block drives one output, `sda_oe`, and the line is pulled low while `sda_oe` is 1. Bus traffic is bit-serial and has no valid/ready stream. Every pin is a plain level: there is no back-pressure, and the host sets the pace through SCL. Write-cycle timing, page buffering, write protection and glitch filtering are outside this block.

Top module: `i2cm_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and the byte pointer is 0. Reset does not clear the memory contents.
- R2: A falling SDA while SCL is high is a start. It makes the block wait for a device address byte, even in the middle of a transfer. A rising SDA while SCL is high is a stop. It returns the block to idle. Both conditions release SDA.
- R3: The device address byte is sent MSB first. Bits 7..4 must equal 1010, bits 3..1 must equal the parameter `DEV_LOW` (default 000), and bit 0 is R/W, where 1 means read. On a match the block pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next start.
- R4: After a write address, the word address follows as two bytes, high byte first, and each byte is acknowledged. The pointer takes the low `ADDR_W` bits (default 11) of the 16-bit value, and the higher bits are ignored.
- R5: Each further byte of a write is stored at the pointer and acknowledged, and the pointer then advances by one. It wraps from 2^ADDR_W-1 to 0.
- R6: A read with no preceding word address returns the byte at the pointer, which equals the last accessed location plus one.
- R7: A dummy write followed by a repeated start and a read address returns the byte at the written word address.
- R8: When the host acknowledges a read byte, the next byte follows from the advanced pointer. The pointer wraps from the last location to 0 and changes only in response to SCL falling.
- R9: After the host does not acknowledge a read byte, SDA stays released for any further clocks until a start.
- R10: Read data goes out MSB first. The block changes `sda_oe` only while SCL is low, except that a start or a stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |

## Verification
The assertions take it for granted that both lines are held for several system clocks around every change. This lets the synchronizer see each SCL edge as one clean event. They also assume the host changes SDA only while SCL is low, apart from the start and stop conditions. The bench keeps to these rules by building every bus bit from ten-cycle low and high phases. It moves SDA two cycles after SCL has fallen, and it creates start and stop conditions only with SCL held high. The bench model predicts the level the block should drive on every clock of each high phase, and this covers acknowledges, data bits, released bits and ignored traffic.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  // protocol engine state
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,     // shifting a byte in from the host
    ST_ACK,    // holding SDA low for the ninth clock
    ST_TX,     // shifting a byte out
    ST_MACK    // host acknowledge slot after a read byte
  } st_e;

  // meaning of the byte being received
  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_WDATA
  } rxk_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cm_line_sync.sv
`timescale 1ns/1ps
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_q = scl_sh[STAGES-1];
  assign sda_q = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cm_mem.sv
`timescale 1ns/1ps
module i2cm_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk)
    if (we) arr[waddr] <= wdata;

  assign rdata = arr[raddr];
endmodule

// File: rtl/i2cm_target.sv
`timescale 1ns/1ps
module i2cm_target #(
  parameter int          ADDR_W      = 11,
  parameter logic [2:0]  DEV_LOW     = 3'b000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2cm_pkg::*;

  localparam logic [6:0] MY_ADDR = {DEV_TYPE, DEV_LOW};

  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  st_e               st;
  rxk_e              kind;
  logic [2:0]        bitn;
  logic              got8;
  logic [7:0]        shreg;
  logic [7:0]        hi_byte;
  logic [7:0]        txd;
  logic              rw;
  logic              mack;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rdata;
  logic [15:0]       word_addr;
  logic              we;
  logic              byte_end;

  assign byte_end  = (st == ST_RX) && scl_fall && got8;
  assign we        = byte_end && (kind == RX_WDATA);
  assign word_addr = {hi_byte, shreg};

  i2cm_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= RX_DEV;
      bitn    <= '0;
      got8    <= 1'b0;
      shreg   <= '0;
      hi_byte <= '0;
      txd     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_RX;
      kind   <= RX_DEV;
      bitn   <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_q};
            if (bitn == 3'd7) got8 <= 1'b1;
            else              bitn <= bitn + 3'd1;
          end
          if (byte_end) begin
            got8 <= 1'b0;
            bitn <= '0;
            unique case (kind)
              RX_DEV: begin
                if (shreg[7:1] == MY_ADDR) begin
                  rw     <= shreg[0];
                  st     <= ST_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end
              RX_AHI: begin
                hi_byte <= shreg;
                st      <= ST_ACK;
                sda_oe  <= 1'b1;
              end
              RX_ALO: begin
                ptr    <= word_addr[ADDR_W-1:0];
                st     <= ST_ACK;
                sda_oe <= 1'b1;
              end
              RX_WDATA: begin
                ptr    <= ptr + 1'b1;
                st     <= ST_ACK;
                sda_oe <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind == RX_DEV && rw) begin
              st     <= ST_TX;
              txd    <= rdata;
              bitn   <= 3'd7;
              sda_oe <= ~rdata[7];
            end else begin
              st     <= ST_RX;
              sda_oe <= 1'b0;
              unique case (kind)
                RX_DEV:   kind <= RX_AHI;
                RX_AHI:   kind <= RX_ALO;
                default:  kind <= RX_WDATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitn == 3'd0) begin
              st     <= ST_MACK;
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
            end else begin
              bitn   <= bitn - 3'd1;
              sda_oe <= ~txd[bitn-3'd1];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_q;
          if (scl_fall) begin
            if (mack) begin
              st     <= ST_TX;
              txd    <= rdata;
              bitn   <= 3'd7;
              sda_oe <= ~rdata[7];
            end else begin
              st     <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_target_chk.sv
`timescale 1ns/1ps
module i2cm_target_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_q,
  input logic          scl_fall,
  input logic          start_evt,
  input logic          stop_evt,
  input logic [AW-1:0] ptr
);
  // R1
  reset_release_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R10
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R10
  release_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_q || $past(start_evt) || $past(stop_evt)));

  // R8
  ptr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));
endmodule

bind i2cm_target i2cm_target_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_q(scl_q),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt), .ptr(ptr)
);

// File: tb/i2cm_target_test.sv
`timescale 1ns/1ps
module i2cm_target_test;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int LOWC = 10;
  localparam int HIC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2cm_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mdl_mem [0:MASK];
  int mdl_ptr = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bus bit; model predicts the block's drive on every high-phase clock
  task automatic bus_bit(input logic m, input logic exp_low, input string tag,
                         output logic seen);
    scl = 1'b0;
    tick(2);
    sda_m = m;
    tick(LOWC);
    scl = 1'b1;
    seen = 1'b1;
    for (int i = 0; i < HIC; i++) begin
      tick(1);
      cmp(sda_oe, exp_low, tag);
      if (i == HIC / 2) seen = sda_line;
    end
    scl = 1'b0;
  endtask

  task automatic bus_start();
    scl = 1'b0;
    tick(2);
    sda_m = 1'b1;
    tick(4);
    scl = 1'b1;
    tick(6);
    sda_m = 1'b0;
    tick(6);
    cmp(sda_oe, 0, "R2 start releases");
  endtask

  task automatic bus_stop();
    scl = 1'b0;
    tick(2);
    sda_m = 1'b0;
    tick(4);
    scl = 1'b1;
    tick(6);
    sda_m = 1'b1;
    tick(6);
    cmp(sda_oe, 0, "R2 stop releases");
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, tag, s);
    bus_bit(1'b1, exp_ack, tag, s);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic host_ack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~exp[i], tag, s);
      got[i] = s;
    end
    cmp(got, exp, tag);
    bus_bit(~host_ack, 1'b0, tag, s);
  endtask

  task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] d [$], input string tag);
    bus_start();
    wr_byte(8'hA0, 1'b1, "R3 write address ack");
    wr_byte(hi, 1'b1, "R4 high word ack");
    wr_byte(lo, 1'b1, "R4 low word ack");
    mdl_ptr = {hi, lo} & MASK;
    foreach (d[k]) begin
      wr_byte(d[k], 1'b1, tag);
      mdl_mem[mdl_ptr] = d[k];
      mdl_ptr = (mdl_ptr + 1) & MASK;
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string tag);
    bus_start();
    wr_byte(8'hA1, 1'b1, "R3 read address ack");
    for (int k = 0; k < n; k++) begin
      rd_byte(mdl_mem[mdl_ptr], k < n - 1, tag);
      mdl_ptr = (mdl_ptr + 1) & MASK;
    end
  endtask

  task automatic dummy_write(input logic [7:0] hi, input logic [7:0] lo);
    bus_start();
    wr_byte(8'hA0, 1'b1, "R3 dummy write ack");
    wr_byte(hi, 1'b1, "R4 high word ack");
    wr_byte(lo, 1'b1, "R4 low word ack");
    mdl_ptr = {hi, lo} & MASK;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic s;
    tick(5);
    cmp(sda_oe, 0, "R1 reset state");
    rst_n = 1'b1;
    tick(5);
    cmp(sda_oe, 0, "R1 after reset");

    // R1: pointer returns to 0 on reset, memory kept
    write_seq(8'h00, 8'h00, '{8'h5A}, "R5 store");
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    mdl_ptr = 0;
    read_body(1, "R1 R6 pointer after reset");
    bus_stop();

    // R5: multi-byte write
    write_seq(8'h00, 8'h10, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R5 data ack");

    // R6: dummy write then stop, then current-address reads
    dummy_write(8'h00, 8'h12);
    bus_stop();
    read_body(1, "R6 R10 current read");
    bus_stop();
    read_body(1, "R6 R10 current read next");
    bus_stop();

    // R7 R8: random sequential read with repeated start
    dummy_write(8'h00, 8'h11);
    read_body(3, "R7 R8 random sequential");
    bus_stop();

    // R3: mismatched type nibble and mismatched low bits are ignored
    bus_start();
    wr_byte(8'hB0, 1'b0, "R3 type mismatch no ack");
    wr_byte(8'h12, 1'b0, "R3 ignored byte");
    bus_stop();
    bus_start();
    wr_byte(8'hA3, 1'b0, "R3 low bits mismatch no ack");
    wr_byte(8'hFF, 1'b0, "R3 ignored byte");
    bus_stop();
    read_body(1, "R3 R6 pointer unchanged");
    bus_stop();

    // R4 R5: upper word bits ignored, write wraps
    write_seq(8'hFF, 8'hFE, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, "R4 R5 wrap write");

    // R8: sequential read wraps to 0
    dummy_write(8'h07, 8'hFE);
    read_body(3, "R8 wrap read");
    bus_stop();

    // R9: after not-acknowledge, extra clocks see SDA released
    read_body(1, "R6 after wrap");
    for (int i = 0; i < 9; i++) bus_bit(1'b1, 1'b0, "R9 released after nack", s);
    bus_stop();

    // R2: start aborts a write in progress; stop returns to idle
    bus_start();
    wr_byte(8'hA0, 1'b1, "R2 write begins");
    bus_start();
    wr_byte(8'hA1, 1'b1, "R2 restart read ack");
    rd_byte(mdl_mem[mdl_ptr], 1'b0, "R2 read after restart");
    mdl_ptr = (mdl_ptr + 1) & MASK;
    bus_stop();
    tick(20);
    cmp(sda_oe, 0, "R2 idle after stop");

    finish_run();
  end
endmodule